// File: doc/BRIEF.md
# Predicated Vector Lane Write-Back

This block sits between the execution lanes of a vector unit and its register file. For each operation it takes the destination register's previous contents, the freshly computed result, the current value of vector register zero, a flag that says whether the operation is predicated, and an active element count. It produces the merged vector and a per-lane write-enable, both registered, together with an output strobe.

The predicate is not kept in a separate mask store. It lives in the low-order bits of vector register zero, one bit per lane. The block therefore has to pull that narrow bit field out of the low elements and fan it out so that bit i reaches lane i. Lanes that are switched off keep their old element. Lanes at or past the active count are never written.

Top module: `vpred_wb`

## Requirements
- R1: In a masked operation, lane i takes its predicate from bit (i mod ELEM_W) of element (i div ELEM_W) of `in_vreg0`. Element k occupies bits [k*ELEM_W +: ELEM_W], and bit 0 is the least significant bit. No other input supplies the predicate.
- R2: In a masked operation, a lane whose predicate bit is 0 has its write-enable low and its output element equal to the old element.
- R3: An enabled lane outputs the new element. Every other lane outputs the old element.
- R4: In an unmasked operation, every lane below the active count is written, whatever `in_vreg0` holds.
- R5: A lane whose index is at or above `in_vl` is never written, whatever its predicate. `in_vl` = 0 writes no lane, and `in_vl` > LANES writes every permitted lane.
- R6: The merged data and the write-enables appear exactly one clock cycle after a cycle with `in_valid` high, with `out_valid` high in that cycle.
- R7: While `rst_n` is low, `out_valid` is 0 and `out_wen` is all zeros.
- R8: A cycle with `in_valid` low produces `out_valid` 0 and an all-zero `out_wen` in the next cycle, and `out_data` keeps its previous value.
- R9: When the destination is register zero (so `in_old` equals `in_vreg0`), the predicate is taken from the `in_vreg0` value presented with that operation.
- R10: Bits of `in_vreg0` at position LANES and above have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Operation present this cycle |
| in_masked | input | 1 | 1 = predicated by register zero, 0 = unpredicated |
| in_vl | input | CNT_W | Active element count |
| in_old | input | LANES*ELEM_W | Previous contents of the destination register |
| in_new | input | LANES*ELEM_W | Result from the execution lanes |
| in_vreg0 | input | LANES*ELEM_W | Current contents of vector register zero |
| out_valid | output | 1 | Registered output strobe |
| out_wen | output | LANES | Registered per-lane write enables |
| out_data | output | LANES*ELEM_W | Registered merged vector |

## Verification
The merge is driven with predicate words whose bits alternate in the low element and form nibble patterns in the second element. A mistake in the bit-to-lane mapping, in element order or in polarity would show on neighbouring lanes. Unmasked runs place noise in register zero to show that the predicate path is bypassed. Runs that leave the low two elements unchanged but alter the upper elements separate a correct low-bit extraction from one that reads the wrong slice. Active counts of 0, 40 and 100 exercise the tail gate below, inside and above the lane range. A run with the destination equal to register zero, followed by an idle cycle, checks that the mask is sampled from the presented value and that the output data is held.

// File: rtl/vpw_pkg.sv
package vpw_pkg;

  typedef enum logic {
    PRED_OFF = 1'b0,
    PRED_ON  = 1'b1
  } pred_mode_e;

  // Width of an element count that can express 0..lanes inclusive.
  function automatic int count_width(input int lanes);
    return $clog2(lanes + 1);
  endfunction

endpackage

// File: rtl/vpw_mask_extract.sv
module vpw_mask_extract
  import vpw_pkg::*;
#(
  parameter int LANES  = 64,
  parameter int ELEM_W = 32
) (
  input  logic [LANES-1:0] pred_field,
  input  pred_mode_e       mode,
  output logic [LANES-1:0] lane_pred
);

  // Fan-out: predicate bit for lane i sits at element i/ELEM_W, bit i%ELEM_W,
  // which in the flattened field is simply position i.
  localparam int ELEMS_USED = (LANES + ELEM_W - 1) / ELEM_W;

  for (genvar e = 0; e < ELEMS_USED; e++) begin : g_elem
    for (genvar b = 0; b < ELEM_W; b++) begin : g_bit
      if (e * ELEM_W + b < LANES) begin : g_lane
        assign lane_pred[e*ELEM_W+b] =
          (mode == PRED_ON) ? pred_field[e*ELEM_W+b] : 1'b1;
      end
    end
  end

endmodule

// File: rtl/vpw_tail_gate.sv
module vpw_tail_gate #(
  parameter int LANES = 64,
  parameter int CNT_W = 7
) (
  input  logic [CNT_W-1:0] active_cnt,
  input  logic [LANES-1:0] lane_pred,
  output logic [LANES-1:0] lane_wen
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic [CNT_W-1:0] IDX = CNT_W'(i);
    assign lane_wen[i] = lane_pred[i] & (IDX < active_cnt);
  end

endmodule

// File: rtl/vpw_lane_merge.sv
module vpw_lane_merge #(
  parameter int LANES  = 64,
  parameter int ELEM_W = 32
) (
  input  logic [LANES-1:0]        lane_wen,
  input  logic [LANES*ELEM_W-1:0] old_vec,
  input  logic [LANES*ELEM_W-1:0] new_vec,
  output logic [LANES*ELEM_W-1:0] merged_vec
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign merged_vec[i*ELEM_W +: ELEM_W] =
      lane_wen[i] ? new_vec[i*ELEM_W +: ELEM_W] : old_vec[i*ELEM_W +: ELEM_W];
  end

endmodule

// File: rtl/vpred_wb.sv
module vpred_wb
  import vpw_pkg::*;
#(
  parameter int LANES  = 64,
  parameter int ELEM_W = 32,
  parameter int CNT_W  = count_width(LANES),
  localparam int REG_W = LANES * ELEM_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_masked,
  input  logic [CNT_W-1:0] in_vl,
  input  logic [REG_W-1:0] in_old,
  input  logic [REG_W-1:0] in_new,
  input  logic [REG_W-1:0] in_vreg0,
  output logic             out_valid,
  output logic [LANES-1:0] out_wen,
  output logic [REG_W-1:0] out_data
);

  pred_mode_e       mode;
  logic [LANES-1:0] lane_pred;
  logic [LANES-1:0] lane_wen;
  logic [REG_W-1:0] merged;

  logic             valid_d;
  logic [LANES-1:0] wen_d;
  logic             data_ce;

  assign mode = in_masked ? PRED_ON : PRED_OFF;

  vpw_mask_extract #(.LANES(LANES), .ELEM_W(ELEM_W)) u_extract (
    .pred_field (in_vreg0[LANES-1:0]),
    .mode       (mode),
    .lane_pred  (lane_pred)
  );

  vpw_tail_gate #(.LANES(LANES), .CNT_W(CNT_W)) u_tail (
    .active_cnt (in_vl),
    .lane_pred  (lane_pred),
    .lane_wen   (lane_wen)
  );

  vpw_lane_merge #(.LANES(LANES), .ELEM_W(ELEM_W)) u_merge (
    .lane_wen   (lane_wen),
    .old_vec    (in_old),
    .new_vec    (in_new),
    .merged_vec (merged)
  );

  // Next state
  always_comb begin
    valid_d = in_valid;
    wen_d   = in_valid ? lane_wen : '0;
    data_ce = in_valid;
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_wen   <= '0;
    end else begin
      out_valid <= valid_d;
      out_wen   <= wen_d;
    end
  end

  // Wide data register: clock-enabled, not reset
  always_ff @(posedge clk) begin
    if (data_ce) begin
      out_data <= merged;
    end
  end

  // Assertions
  AST_STROBE_FOLLOWS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R6
  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && out_wen == '0)); // R8
  AST_IDLE_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && $past(in_valid)) |=> $stable(out_data)); // R8
  AST_UNMASKED_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_masked && in_vl >= CNT_W'(LANES)) |=> (&out_wen)); // R4
  AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_vl == '0) |=> (out_wen == '0)); // R5
  AST_PRED_OFF_LANE0: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_masked && !in_vreg0[0]) |=> !out_wen[0]); // R2
  AST_LANE0_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_data[ELEM_W-1:0] ==
      (out_wen[0] ? $past(in_new[ELEM_W-1:0]) : $past(in_old[ELEM_W-1:0])))); // R3
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && out_wen == '0)); // R7

endmodule

// File: tb/tb_vpred_wb.sv
`timescale 1ns/1ps
module tb_vpred_wb;

  localparam int LANES  = 64;
  localparam int ELEM_W = 32;
  localparam int CNT_W  = $clog2(LANES + 1);
  localparam int REG_W  = LANES * ELEM_W;

  logic             clk;
  logic             rst_n;
  logic             in_valid;
  logic             in_masked;
  logic [CNT_W-1:0] in_vl;
  logic [REG_W-1:0] in_old, in_new, in_vreg0;
  logic             out_valid;
  logic [LANES-1:0] out_wen;
  logic [REG_W-1:0] out_data;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  logic [REG_W-1:0] last_data;

  vpred_wb #(.LANES(LANES), .ELEM_W(ELEM_W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_masked(in_masked),
    .in_vl(in_vl), .in_old(in_old), .in_new(in_new), .in_vreg0(in_vreg0),
    .out_valid(out_valid), .out_wen(out_wen), .out_data(out_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [REG_W-1:0] fill(input logic [31:0] seed);
    logic [REG_W-1:0] v;
    for (int k = 0; k < LANES; k++)
      v[k*ELEM_W +: ELEM_W] = ELEM_W'(seed * 32'h0100_0193 + k * 32'h9E37_79B9);
    return v;
  endfunction

  task automatic check(input string req, input logic [REG_W-1:0] act,
                       input logic [REG_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one operation, then check the registered outputs one cycle later.
  task automatic run_op(input string req, input bit masked, input int vl,
                        input logic [REG_W-1:0] old_v, input logic [REG_W-1:0] new_v,
                        input logic [REG_W-1:0] v0);
    logic [LANES-1:0] ew;
    logic [REG_W-1:0] ed;
    for (int i = 0; i < LANES; i++) begin
      // mask bit for lane i: element i/ELEM_W, bit i%ELEM_W
      logic pb;
      pb = masked ? v0[(i / ELEM_W) * ELEM_W + (i % ELEM_W)] : 1'b1;
      ew[i] = pb && (i < vl);
      ed[i*ELEM_W +: ELEM_W] = ew[i] ? new_v[i*ELEM_W +: ELEM_W]
                                     : old_v[i*ELEM_W +: ELEM_W];
    end
    @(negedge clk);
    in_valid = 1'b1; in_masked = masked; in_vl = CNT_W'(vl);
    in_old = old_v; in_new = new_v; in_vreg0 = v0;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " R6 strobe"}, REG_W'(out_valid), REG_W'(1'b1));
    check({req, " wen"}, REG_W'(out_wen), REG_W'(ew));
    check({req, " data"}, out_data, ed);
    last_data = ed;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; in_valid = 1'b0; in_masked = 1'b0; in_vl = '0;
    in_old = '0; in_new = '0; in_vreg0 = '0;
    repeat (3) @(negedge clk);
    check("R7 reset valid", REG_W'(out_valid), '0);
    check("R7 reset wen", REG_W'(out_wen), '0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_unmasked;
    run_op("R4 unmasked noisy v0", 1'b0, LANES, fill(1), fill(2), fill(3));
    run_op("R4 unmasked zero v0", 1'b0, LANES, fill(4), fill(5), '0);
  endtask

  task automatic t_masked_patterns;
    logic [REG_W-1:0] v0;
    v0 = fill(7);
    v0[31:0]  = 32'hAAAA_5555;
    v0[63:32] = 32'h0F0F_F0F0;
    run_op("R1 R2 R3 masked pattern", 1'b1, LANES, fill(8), fill(9), v0);
    v0[REG_W-1:LANES] = ~v0[REG_W-1:LANES];
    run_op("R10 upper bits flipped", 1'b1, LANES, fill(8), fill(9), v0);
    v0 = '0;
    v0[63:32] = 32'hFFFF_FFFF;
    run_op("R1 element1 only", 1'b1, LANES, fill(10), fill(11), v0);
  endtask

  task automatic t_tail;
    logic [REG_W-1:0] v0;
    v0 = fill(12);
    v0[63:0] = 64'hFFFF_FFFF_FFFF_FFFF;
    run_op("R5 masked vl=40", 1'b1, 40, fill(13), fill(14), v0);
    run_op("R5 unmasked vl=0", 1'b0, 0, fill(15), fill(16), fill(17));
    run_op("R5 unmasked vl=100", 1'b0, 100, fill(18), fill(19), '0);
  endtask

  task automatic t_dest_v0;
    logic [REG_W-1:0] v0;
    v0 = fill(20);
    v0[63:0] = 64'h1234_5678_9ABC_DEF0;
    run_op("R9 dest is v0", 1'b1, LANES, v0, fill(21), v0);
  endtask

  task automatic t_idle;
    @(negedge clk);
    in_new = fill(99); in_old = fill(98); in_vl = CNT_W'(LANES); in_masked = 1'b0;
    check("R8 idle valid", REG_W'(out_valid), '0);
    check("R8 idle wen", REG_W'(out_wen), '0);
    check("R8 idle data held", out_data, last_data);
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    t_reset();
    t_unmasked();
    t_masked_patterns();
    t_tail();
    t_dest_v0();
    t_idle();
    done = 1;
    summary();
    $finish;
  end

endmodule